// File: doc/BRIEF.md
# Vertical-Sync Shadow Register Bank

This block holds the configuration registers of a display compositor as pairs: a working copy that the host writes, and a shadow copy that drives the display pipeline. Working values reach the shadows only on a vertical-sync pulse. A software sync-enable bit must be set for that to happen. In the default variant, an explicit layer-update request must also be outstanding. Software can therefore clear sync-enable, rewrite several registers, and re-arm the transfer, and the pipeline never sees a half-written set.

A separate video-layer base register has its own transfer flag. The host sets the flag and the block clears it once the copy has been made. A sticky vertical-sync interrupt status bit, with a mask, produces the blanking interrupt. In interlaced scan, the interrupt event is skipped on any sync pulse at which a shadow still differs from its working value or a video transfer is still pending. Every shadow can be read back at an address of its own, so software can compare it with the working copy. A soft-reset command returns every register to zero.

Top module: `shadow_reg_bank`

Register words, 4-bit word address:

| Address | Name | Access |
|---|---|---|
| 0 | CTRL | bit0 sync-enable, bit1 soft reset (write 1, reads 0), bit2 interlace, bit3 video enable |
| 1 | CFG | working |
| 2 | UPDATE | write bit0=1 to request an update; reads the pending count |
| 3 | GFX0 | working |
| 4 | GFX1 | working |
| 5 | VIDFLAG | bit0 |
| 6 | VID | working |
| 7 | IRQST | bit0, write 1 to clear |
| 8 | IRQMSK | bit0 |
| 9 | CFG shadow | read only |
| 10 | GFX0 shadow | read only |
| 11 | GFX1 shadow | read only |
| 12 | VID shadow | read only |
| 13 | SYNC | bit0 in sync, read only |

## Requirements
- R1: After reset, every register reads 0 except SYNC (address 13), which reads 1, and vblankIrq is low.
- R2: While sync-enable (CTRL bit0) is 0, a vertical-sync pulse leaves every shadow and every active output unchanged.
- R3: At a sync pulse with sync-enable set and a pending count above 0, CFG, GFX0 and GFX1 are all copied to their shadows on that one clock edge, and the pending count becomes 0.
- R4: Writing 1 to bit0 of UPDATE (address 2) adds one to the pending count, which saturates at 3. SYNC bit0 reads 1 exactly when the count is 0.
- R5: A sync pulse with sync-enable set and a pending count of 0 does not copy CFG, GFX0 or GFX1.
- R6: Writing 1 to VIDFLAG bit0 sets the flag only while video enable (CTRL bit3) is 1. At a sync pulse with sync-enable set and the flag set, VID is copied to its shadow and the flag clears.
- R7: Host writes to addresses 9 to 13 are ignored. Reads at those addresses return the shadow values and the sync status, with no wait state.
- R8: In progressive scan (CTRL bit2 = 0), each sync pulse sets IRQST bit0. Writing 1 to IRQST bit0 clears it. vblankIrq is high exactly when IRQST bit0 and IRQMSK bit0 are both 1.
- R9: In interlaced scan (CTRL bit2 = 1), a sync pulse sets IRQST bit0 only if every shadow equals its working value and no video transfer is pending, judged on the values present before that pulse.
- R10: Writing CTRL with bit1 = 1 returns every register, shadows included, to zero on the next edge, and the rest of the written value is discarded.
- R11: An update request written in the same cycle as a sync pulse that performs a transfer leaves the pending count at 1 after the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWe | input | 1 | Host write strobe for one cycle |
| hostAddr | input | 4 | Host word address |
| hostWdata | input | DATA_W | Host write data |
| hostRdata | output | DATA_W | Read data for hostAddr, combinational |
| vsyncPulse | input | 1 | One-cycle vertical-sync pulse |
| cfgActive | output | DATA_W | Shadow configuration value in use |
| gfxBaseActive | output | NUM_GFX*DATA_W | Shadow graphic-layer base addresses, layer i at bits i*DATA_W and up |
| vidBaseActive | output | DATA_W | Shadow video-layer base address |
| vblankIrq | output | 1 | Blanking interrupt |

## Verification
A write or a sync pulse sampled on one edge changes the registers on that same edge. Active outputs, the interrupt line and read data are therefore due one edge after the cycle in which the stimulus is held. Read data is combinational from the registers, so a value read at a new address is due in the same cycle as that address. The bench drives its inputs just after a rising edge and advances its reference model on the rising edge. It compares every output, and the read data at the current address, on the falling edge that follows, where each result is already due and stable.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int ADDR_W  = 4;
  localparam int NUM_GFX = 2;
  localparam int CTRL_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CFG     = 4'd1;
  localparam logic [ADDR_W-1:0] A_UPD     = 4'd2;
  localparam logic [ADDR_W-1:0] A_GFX0    = 4'd3;
  localparam logic [ADDR_W-1:0] A_VIDFLAG = 4'd5;
  localparam logic [ADDR_W-1:0] A_VID     = 4'd6;
  localparam logic [ADDR_W-1:0] A_IRQST   = 4'd7;
  localparam logic [ADDR_W-1:0] A_IRQMSK  = 4'd8;
  localparam logic [ADDR_W-1:0] A_CFG_S   = 4'd9;
  localparam logic [ADDR_W-1:0] A_GFX0_S  = 4'd10;
  localparam logic [ADDR_W-1:0] A_VID_S   = 4'd12;
  localparam logic [ADDR_W-1:0] A_SYNC    = 4'd13;

  localparam int B_SYNC  = 0;
  localparam int B_SRST  = 1;
  localparam int B_INTER = 2;
  localparam int B_VIDEN = 3;

  typedef struct packed {
    logic               softReset;
    logic               wrCfg;
    logic [NUM_GFX-1:0] wrGfx;
    logic               wrVid;
    logic               xferMain;
    logic               xferVid;
  } strobe_t;
endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_pkg::*;
#(
  parameter int COUNT_W          = 2,
  parameter bit HAS_LAYER_UPDATE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [CTRL_W-1:0]  hostWbits,
  input  logic               vsyncPulse,
  input  logic               allMatch,
  output strobe_t            strb,
  output logic               syncEn,
  output logic               interlace,
  output logic               videoEn,
  output logic [COUNT_W-1:0] pendCnt,
  output logic               vidFlag,
  output logic               irqSt,
  output logic               irqMask,
  output logic               synced
);
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic xferMainW;
  logic vidPend;
  logic irqEvent;
  logic irqClr;
  logic vidSet;

  assign vidPend  = videoEn && vidFlag;
  assign irqEvent = vsyncPulse && (!interlace || (allMatch && !vidPend));
  assign irqClr   = hostWe && (hostAddr == A_IRQST) && hostWbits[0];
  assign vidSet   = hostWe && (hostAddr == A_VIDFLAG) && hostWbits[0] && videoEn;

  always_comb begin
    strb           = '0;
    strb.softReset = hostWe && (hostAddr == A_CTRL) && hostWbits[B_SRST];
    strb.wrCfg     = hostWe && (hostAddr == A_CFG);
    for (int i = 0; i < NUM_GFX; i++)
      strb.wrGfx[i] = hostWe && (hostAddr == A_GFX0 + ADDR_W'(i));
    strb.wrVid     = hostWe && (hostAddr == A_VID);
    strb.xferMain  = xferMainW;
    strb.xferVid   = vsyncPulse && syncEn && vidFlag;
  end

  // control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncEn    <= 1'b0;
      interlace <= 1'b0;
      videoEn   <= 1'b0;
    end else if (strb.softReset) begin
      syncEn    <= 1'b0;
      interlace <= 1'b0;
      videoEn   <= 1'b0;
    end else if (hostWe && hostAddr == A_CTRL) begin
      syncEn    <= hostWbits[B_SYNC];
      interlace <= hostWbits[B_INTER];
      videoEn   <= hostWbits[B_VIDEN];
    end
  end

  // video transfer flag and interrupt state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidFlag <= 1'b0;
      irqSt   <= 1'b0;
      irqMask <= 1'b0;
    end else if (strb.softReset) begin
      vidFlag <= 1'b0;
      irqSt   <= 1'b0;
      irqMask <= 1'b0;
    end else begin
      vidFlag <= (vidFlag && !strb.xferVid) || vidSet;
      irqSt   <= (irqSt && !irqClr) || irqEvent;
      if (hostWe && hostAddr == A_IRQMSK) irqMask <= hostWbits[0];
    end
  end

  generate
    if (HAS_LAYER_UPDATE) begin : g_counted
      logic reqUpd;
      logic [COUNT_W-1:0] cntBase;
      assign reqUpd    = hostWe && (hostAddr == A_UPD) && hostWbits[0];
      assign xferMainW = vsyncPulse && syncEn && (pendCnt != '0);
      assign cntBase   = xferMainW ? '0 : pendCnt;
      assign synced    = (pendCnt == '0);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                             pendCnt <= '0;
        else if (strb.softReset)               pendCnt <= '0;
        else if (reqUpd && cntBase != CNT_MAX) pendCnt <= cntBase + 1'b1;
        else                                   pendCnt <= cntBase;
      end
    end else begin : g_plain
      assign xferMainW = vsyncPulse && syncEn;
      assign pendCnt   = '0;
      assign synced    = allMatch && !vidPend;
    end
  endgenerate
endmodule

// File: rtl/shadow_data.sv
module shadow_data
  import shadow_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        strb,
  input  logic [DATA_W-1:0]              hostWdata,
  output logic [DATA_W-1:0]              cfgWork,
  output logic [DATA_W-1:0]              cfgShadow,
  output logic [NUM_GFX-1:0][DATA_W-1:0] gfxWork,
  output logic [NUM_GFX-1:0][DATA_W-1:0] gfxShadow,
  output logic [DATA_W-1:0]              vidWork,
  output logic [DATA_W-1:0]              vidShadow,
  output logic                           allMatch
);
  // configuration pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWork   <= '0;
      cfgShadow <= '0;
    end else if (strb.softReset) begin
      cfgWork   <= '0;
      cfgShadow <= '0;
    end else begin
      if (strb.xferMain) cfgShadow <= cfgWork;
      if (strb.wrCfg)    cfgWork   <= hostWdata;
    end
  end

  // graphic layer base pairs
  generate
    for (genvar g = 0; g < NUM_GFX; g++) begin : g_gfx
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          gfxWork[g]   <= '0;
          gfxShadow[g] <= '0;
        end else if (strb.softReset) begin
          gfxWork[g]   <= '0;
          gfxShadow[g] <= '0;
        end else begin
          if (strb.xferMain) gfxShadow[g] <= gfxWork[g];
          if (strb.wrGfx[g]) gfxWork[g]   <= hostWdata;
        end
      end
    end
  endgenerate

  // video layer base pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidWork   <= '0;
      vidShadow <= '0;
    end else if (strb.softReset) begin
      vidWork   <= '0;
      vidShadow <= '0;
    end else begin
      if (strb.xferVid) vidShadow <= vidWork;
      if (strb.wrVid)   vidWork   <= hostWdata;
    end
  end

  always_comb begin
    allMatch = (cfgWork == cfgShadow) && (vidWork == vidShadow);
    for (int i = 0; i < NUM_GFX; i++)
      if (gfxWork[i] != gfxShadow[i]) allMatch = 1'b0;
  end
endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
  import shadow_pkg::*;
#(
  parameter int DATA_W           = 32,
  parameter int COUNT_W          = 2,
  parameter bit HAS_LAYER_UPDATE = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hostWe,
  input  logic [ADDR_W-1:0]         hostAddr,
  input  logic [DATA_W-1:0]         hostWdata,
  output logic [DATA_W-1:0]         hostRdata,
  input  logic                      vsyncPulse,
  output logic [DATA_W-1:0]         cfgActive,
  output logic [NUM_GFX*DATA_W-1:0] gfxBaseActive,
  output logic [DATA_W-1:0]         vidBaseActive,
  output logic                      vblankIrq
);
  strobe_t strb;
  logic syncEn, interlace, videoEn, vidFlag, irqSt, irqMask, synced, allMatch;
  logic [COUNT_W-1:0] pendCnt;
  logic [DATA_W-1:0] cfgWork, cfgShadow, vidWork, vidShadow;
  logic [NUM_GFX-1:0][DATA_W-1:0] gfxWork, gfxShadow;

  shadow_ctrl #(.COUNT_W(COUNT_W), .HAS_LAYER_UPDATE(HAS_LAYER_UPDATE)) i_ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWbits(hostWdata[CTRL_W-1:0]), .vsyncPulse(vsyncPulse), .allMatch(allMatch),
    .strb(strb), .syncEn(syncEn), .interlace(interlace), .videoEn(videoEn),
    .pendCnt(pendCnt), .vidFlag(vidFlag), .irqSt(irqSt), .irqMask(irqMask),
    .synced(synced)
  );

  shadow_data #(.DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWdata(hostWdata),
    .cfgWork(cfgWork), .cfgShadow(cfgShadow), .gfxWork(gfxWork),
    .gfxShadow(gfxShadow), .vidWork(vidWork), .vidShadow(vidShadow),
    .allMatch(allMatch)
  );

  assign cfgActive     = cfgShadow;
  assign gfxBaseActive = gfxShadow;
  assign vidBaseActive = vidShadow;
  assign vblankIrq     = irqSt && irqMask;

  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      A_CTRL:    hostRdata = DATA_W'({videoEn, interlace, 1'b0, syncEn});
      A_CFG:     hostRdata = cfgWork;
      A_UPD:     hostRdata = DATA_W'(pendCnt);
      A_VIDFLAG: hostRdata = DATA_W'(vidFlag);
      A_VID:     hostRdata = vidWork;
      A_IRQST:   hostRdata = DATA_W'(irqSt);
      A_IRQMSK:  hostRdata = DATA_W'(irqMask);
      A_CFG_S:   hostRdata = cfgShadow;
      A_VID_S:   hostRdata = vidShadow;
      A_SYNC:    hostRdata = DATA_W'(synced);
      default:   hostRdata = '0;
    endcase
    for (int i = 0; i < NUM_GFX; i++) begin
      if (hostAddr == A_GFX0 + ADDR_W'(i))   hostRdata = gfxWork[i];
      if (hostAddr == A_GFX0_S + ADDR_W'(i)) hostRdata = gfxShadow[i];
    end
  end
endmodule

// File: rtl/shadow_checker.sv
module shadow_checker
  import shadow_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 2
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      vsyncPulse,
  input logic                      softReset,
  input logic                      syncEn,
  input logic                      interlace,
  input logic                      videoEn,
  input logic                      vidFlag,
  input logic                      irqSt,
  input logic                      allMatch,
  input logic [COUNT_W-1:0]        pendCnt,
  input logic [DATA_W-1:0]         cfgWork,
  input logic [DATA_W-1:0]         vidWork,
  input logic [DATA_W-1:0]         cfgActive,
  input logic [NUM_GFX*DATA_W-1:0] gfxBaseActive,
  input logic [DATA_W-1:0]         vidBaseActive
);
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!syncEn && !softReset) |=> ($stable(cfgActive) && $stable(gfxBaseActive) && $stable(vidBaseActive))); // R2
  AST_MAIN_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncPulse && syncEn && pendCnt != '0 && !softReset) |=> (cfgActive == $past(cfgWork))); // R3
  AST_PEND_MONO: assert property (@(posedge clk) disable iff (!rstN)
    (!vsyncPulse && !softReset) |=> (pendCnt >= $past(pendCnt))); // R4
  AST_IDLE_NO_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncPulse && pendCnt == '0 && !softReset) |=> $stable(cfgActive)); // R5
  AST_VID_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncPulse && syncEn && vidFlag && !softReset) |=> (vidBaseActive == $past(vidWork))); // R6
  AST_INTERLACE_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncPulse && interlace && !(allMatch && !(videoEn && vidFlag)) && !irqSt) |=> !irqSt); // R9
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (cfgActive == '0 && pendCnt == '0 && !syncEn && !irqSt)); // R10
endmodule

bind shadow_reg_bank shadow_checker #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) i_checker (
  .clk(clk), .rstN(rstN), .vsyncPulse(vsyncPulse), .softReset(strb.softReset),
  .syncEn(syncEn), .interlace(interlace), .videoEn(videoEn), .vidFlag(vidFlag),
  .irqSt(irqSt), .allMatch(allMatch), .pendCnt(pendCnt), .cfgWork(cfgWork),
  .vidWork(vidWork), .cfgActive(cfgActive), .gfxBaseActive(gfxBaseActive),
  .vidBaseActive(vidBaseActive)
);

// File: tb/test_shadow_reg_bank.sv
`timescale 1ns/1ps
module test_shadow_reg_bank;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 1'b0;
  logic [3:0] hostAddr = '0;
  logic [DW-1:0] hostWdata = '0;
  logic vsyncPulse = 1'b0;
  logic [DW-1:0] hostRdata, cfgActive, vidBaseActive;
  logic [2*DW-1:0] gfxBaseActive;
  logic vblankIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shadow_reg_bank i_shadow_reg_bank (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .vsyncPulse(vsyncPulse),
    .cfgActive(cfgActive), .gfxBaseActive(gfxBaseActive),
    .vidBaseActive(vidBaseActive), .vblankIrq(vblankIrq)
  );

  // reference model
  logic mSync, mInter, mVidEn, mVidFlag, mIrq, mMask;
  logic [DW-1:0] mCfgW, mCfgS, mVidW, mVidS;
  logic [DW-1:0] mGfxW [2];
  logic [DW-1:0] mGfxS [2];
  int mCnt;

  function automatic logic [DW-1:0] mRead(input logic [3:0] a);
    case (a)
      0: return {28'd0, mVidEn, mInter, 1'b0, mSync};
      1: return mCfgW;
      2: return DW'(mCnt);
      3: return mGfxW[0];
      4: return mGfxW[1];
      5: return DW'(mVidFlag);
      6: return mVidW;
      7: return DW'(mIrq);
      8: return DW'(mMask);
      9: return mCfgS;
      10: return mGfxS[0];
      11: return mGfxS[1];
      12: return mVidS;
      13: return DW'(mCnt == 0);
      default: return '0;
    endcase
  endfunction

  task automatic mClear();
    mSync = 0; mInter = 0; mVidEn = 0; mVidFlag = 0; mIrq = 0; mMask = 0;
    mCfgW = 0; mCfgS = 0; mVidW = 0; mVidS = 0; mCnt = 0;
    mGfxW[0] = 0; mGfxW[1] = 0; mGfxS[0] = 0; mGfxS[1] = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) mClear();
    else if (hostWe && hostAddr == 0 && hostWdata[1]) mClear();
    else begin
      logic xm, xv, match, evt;
      xm = vsyncPulse && mSync && mCnt != 0;
      xv = vsyncPulse && mSync && mVidFlag;
      match = mCfgW == mCfgS && mGfxW[0] == mGfxS[0] && mGfxW[1] == mGfxS[1]
              && mVidW == mVidS && !(mVidEn && mVidFlag);
      evt = vsyncPulse && (!mInter || match);
      if (xm) begin mCfgS = mCfgW; mGfxS[0] = mGfxW[0]; mGfxS[1] = mGfxW[1]; mCnt = 0; end
      if (xv) begin mVidS = mVidW; mVidFlag = 0; end
      if (hostWe) begin
        case (hostAddr)
          0: begin mSync = hostWdata[0]; mInter = hostWdata[2]; mVidEn = hostWdata[3]; end
          1: mCfgW = hostWdata;
          2: if (hostWdata[0] && mCnt < 3) mCnt++;
          3: mGfxW[0] = hostWdata;
          4: mGfxW[1] = hostWdata;
          5: if (hostWdata[0] && mVidEn) mVidFlag = 1;
          6: mVidW = hostWdata;
          7: if (hostWdata[0]) mIrq = 0;
          8: mMask = hostWdata[0];
          default: ;
        endcase
      end
      if (evt) mIrq = 1;
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3 cfg shadow output", cfgActive, mCfgS);
      check("R3 gfx0 shadow output", gfxBaseActive[DW-1:0], mGfxS[0]);
      check("R3 gfx1 shadow output", gfxBaseActive[2*DW-1:DW], mGfxS[1]);
      check("R6 video shadow output", vidBaseActive, mVidS);
      check("R8 interrupt line", DW'(vblankIrq), DW'(mIrq && mMask));
      check("R7 read data", hostRdata, mRead(hostAddr));
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    hostWe = 1; hostAddr = a; hostWdata = d; step(); hostWe = 0;
  endtask
  task automatic vs(); vsyncPulse = 1; step(); vsyncPulse = 0; endtask
  task automatic rdChk(input logic [3:0] a, input logic [DW-1:0] exp, input string tag);
    hostAddr = a; @(negedge clk); check(tag, hostRdata, exp); step();
  endtask
  task automatic irqChk(input logic exp, input string tag);
    @(negedge clk); check(tag, DW'(vblankIrq), DW'(exp)); step();
  endtask

  task automatic finishSim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishSim();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    step();
    // R1 reset state
    rdChk(13, 1, "R1 sync status");
    rdChk(1, 0, "R1 cfg");
    rdChk(7, 0, "R1 irq status");
    irqChk(0, "R1 interrupt low");
    // R2 no transfer while sync disabled
    wr(1, 'hA5); wr(3, 'h1000); wr(4, 'h2000); wr(2, 1);
    vs();
    rdChk(9, 0, "R2 cfg shadow held");
    rdChk(2, 1, "R4 pending count");
    rdChk(13, 0, "R4 sync status");
    // R3 transfer
    wr(0, 1); vs();
    rdChk(9, 'hA5, "R3 cfg shadow");
    rdChk(11, 'h2000, "R3 gfx1 shadow");
    rdChk(2, 0, "R3 count cleared");
    // R5 no request, no copy
    wr(1, 'h5A); vs();
    rdChk(9, 'hA5, "R5 no copy");
    // R4 saturation
    repeat (4) wr(2, 1);
    rdChk(2, 3, "R4 saturate");
    vs();
    rdChk(9, 'h5A, "R3 copy after saturation");
    // R7 shadow writes ignored
    wr(9, 'hFFFF);
    rdChk(9, 'h5A, "R7 cfg shadow write ignored");
    wr(10, '1); wr(13, 0);
    rdChk(10, 'h1000, "R7 gfx0 shadow write ignored");
    rdChk(13, 1, "R7 sync status write ignored");
    // R6 video path
    wr(5, 1);
    rdChk(5, 0, "R6 flag needs video enable");
    wr(0, 9); wr(6, 'hBEEF); wr(5, 1);
    rdChk(5, 1, "R6 flag set");
    rdChk(12, 0, "R6 video shadow held");
    vs();
    rdChk(12, 'hBEEF, "R6 video shadow");
    rdChk(5, 0, "R6 flag cleared");
    // R8 interrupt
    rdChk(7, 1, "R8 sticky status");
    irqChk(0, "R8 masked");
    wr(8, 1);
    irqChk(1, "R8 unmasked");
    wr(7, 1);
    rdChk(7, 0, "R8 write one clears");
    vs();
    rdChk(7, 1, "R8 set by vsync");
    // R9 interlace gating
    wr(7, 1); wr(0, 'hD); wr(1, 'h77);
    vs();
    rdChk(7, 0, "R9 skipped on mismatch");
    wr(2, 1); vs();
    rdChk(7, 0, "R9 skipped on transfer pulse");
    rdChk(9, 'h77, "R3 interlace copy");
    vs();
    rdChk(7, 1, "R9 set when matched");
    // R11 request during transfer
    wr(2, 1); wr(1, 'h99);
    hostWe = 1; hostAddr = 2; hostWdata = 1; vsyncPulse = 1;
    step();
    hostWe = 0; vsyncPulse = 0;
    rdChk(2, 1, "R11 count after concurrent request");
    rdChk(9, 'h99, "R11 copy happened");
    // R10 soft reset
    wr(0, 'hB);
    rdChk(0, 0, "R10 ctrl");
    rdChk(9, 0, "R10 cfg shadow");
    rdChk(2, 0, "R10 count");
    rdChk(1, 0, "R10 cfg");
    rdChk(7, 0, "R10 irq status");
    rdChk(12, 0, "R10 video shadow");
    step();
    finishSim();
  end
endmodule